// File: doc/BRIEF.md
# Interrupting Parallel Pin Port

A 32-pin general-purpose pin block on a plain 32-bit register bus. Software picks, per pin, whether the pin drives and whether its level is sampled. It sets the drive value and can flip any driven bit through a separate inversion mask. A pin that drives sees its own driven value at its input side. A pin that does not drive sees the external pad level. That level passes through a two-flop synchronizer and is then gated by the input enable to form the sampled input value.

Four pending banks follow the sampled input value: rising transition, falling transition, level high and level low. Each bank has its own per-pin enable. Pending bits are set whether or not they are enabled, and software clears them by writing ones. One interrupt line is the OR of every enabled pending bit. Since the sampled value is gated, changing an input enable or an output enable can itself produce transitions.

Top module: `pin_port_irq`

## Requirements
- R1: While reset is asserted, every register reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: `pad_oe` equals the drive-enable register (offset 0x08). `pad_out` equals the drive value (0x0C) XOR the inversion mask (0x40). Clearing a drive enable leaves the readback of the drive value unchanged.
- R3: Offset 0x00 reads the synchronized pin level ANDed with the input-enable register (0x04). A driven pin uses its own `pad_out` bit and an undriven pin uses `pad_in`. A write to the drive value shows at offset 0x00 two cycles after the write edge and not one.
- R4: A rising-pending bit (0x1C) is set when its sampled input bit goes 0 to 1, and a falling-pending bit (0x24) is set when it goes 1 to 0. This happens whatever the enables are, and includes transitions caused by changing the input enable.
- R5: A high-pending bit (0x2C) or low-pending bit (0x34) is set on every cycle its sampled input bit is 1 or 0. After reset, every low-pending bit becomes set because the sampled input reads 0.
- R6: Writing to a pending register clears the bits written as 1 and leaves the bits written as 0. A level-pending bit whose level still holds stays set through the clear.
- R7: `irq` is 1 exactly when some pin has a pending bit set together with its enable: rise 0x18, fall 0x20, high 0x28, low 0x30. Enabling a high enable on a pin that is already high raises `irq` with no new transition.
- R8: Writes to offset 0x00 have no effect. Reads from unmapped offsets (for example 0x10) return 0.
- R9: The enable registers, drive value and inversion mask read back the last value written at their offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | External pin levels |
| pad_out | output | 32 | Drive value per pin |
| pad_oe | output | 32 | Drive enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted synchronizer or transition-history flop shows at offset 0x00, or as a wrong rising- or falling-pending bit, within three cycles of a drive write. A corrupted enable or pending bit reaches `irq` in the same cycle, because that output is combinational from the bank registers. A wrong clear mask or a wrong set priority shows on the first read after a write-one-to-clear while a level persists. A drive register that changes without a write shows at once on `pad_out` or `pad_oe`.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int NUM_BANKS   = 4;
  localparam int BANK_STRIDE = 8;

  typedef enum logic [1:0] {
    EV_RISE = 2'd0,
    EV_FALL = 2'd1,
    EV_HIGH = 2'd2,
    EV_LOW  = 2'd3
  } ev_kind_e;

  localparam int OFS_IN_VAL  = 'h00;
  localparam int OFS_IN_EN   = 'h04;
  localparam int OFS_OUT_EN  = 'h08;
  localparam int OFS_OUT_VAL = 'h0C;
  localparam int OFS_IE_BASE = 'h18;
  localparam int OFS_IP_BASE = 'h1C;
  localparam int OFS_OUT_XOR = 'h40;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_pend_bank.sv
module pin_pend_bank
  import pin_port_pkg::*;
#(
  parameter int       W    = 32,
  parameter ev_kind_e KIND = EV_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         ie_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ie,
  output logic [W-1:0] ip,
  output logic         hit
);
  logic [W-1:0] set_vec;
  logic [W-1:0] ie_d, ip_d;

  if (KIND == EV_RISE) begin : g_rise
    assign set_vec = cur & ~prev;
  end else if (KIND == EV_FALL) begin : g_fall
    assign set_vec = ~cur & prev;
  end else if (KIND == EV_HIGH) begin : g_high
    assign set_vec = cur;
  end else begin : g_low
    assign set_vec = ~cur;
  end

  always_comb begin
    ie_d = ie;
    if (ie_we) ie_d = wdata;
    ip_d = ip;
    if (clr_we) ip_d = ip_d & ~wdata;
    ip_d = ip_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= '0;
      ip <= '0;
    end else begin
      ie <= ie_d;
      ip <= ip_d;
    end
  end

  assign hit = |(ie & ip);
endmodule

// File: rtl/pin_port_irq.sv
module pin_port_irq
  import pin_port_pkg::*;
#(
  parameter int PINS = 32,
  parameter int AW   = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq
);
  localparam int NB = NUM_BANKS;

  logic rst_int_n;
  pin_sync #(.W(1), .STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  logic [PINS-1:0] in_en_q, out_en_q, out_val_q, out_xor_q;
  logic [PINS-1:0] in_en_d, out_en_d, out_val_d, out_xor_d;

  always_comb begin
    in_en_d   = in_en_q;
    out_en_d  = out_en_q;
    out_val_d = out_val_q;
    out_xor_d = out_xor_q;
    if (bus_we) begin
      if (bus_addr == AW'(OFS_IN_EN))   in_en_d   = bus_wdata;
      if (bus_addr == AW'(OFS_OUT_EN))  out_en_d  = bus_wdata;
      if (bus_addr == AW'(OFS_OUT_VAL)) out_val_d = bus_wdata;
      if (bus_addr == AW'(OFS_OUT_XOR)) out_xor_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      in_en_q   <= '0;
      out_en_q  <= '0;
      out_val_q <= '0;
      out_xor_q <= '0;
    end else begin
      in_en_q   <= in_en_d;
      out_en_q  <= out_en_d;
      out_val_q <= out_val_d;
      out_xor_q <= out_xor_d;
    end
  end

  assign pad_out = out_val_q ^ out_xor_q;
  assign pad_oe  = out_en_q;

  logic [PINS-1:0] pad_seen, pad_sync, in_val, prev_q;
  assign pad_seen = (pad_oe & pad_out) | (~pad_oe & pad_in);

  pin_sync #(.W(PINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pad_seen), .q(pad_sync)
  );

  assign in_val = pad_sync & in_en_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) prev_q <= '0;
    else            prev_q <= in_val;
  end

  logic [NB-1:0][PINS-1:0] bank_ie, bank_ip;
  logic [NB-1:0]           bank_hit;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    logic ie_sel, ip_sel;
    assign ie_sel = bus_we && (bus_addr == AW'(OFS_IE_BASE + BANK_STRIDE * k));
    assign ip_sel = bus_we && (bus_addr == AW'(OFS_IP_BASE + BANK_STRIDE * k));
    pin_pend_bank #(.W(PINS), .KIND(ev_kind_e'(k))) u_bank (
      .clk(clk), .rst_n(rst_int_n),
      .cur(in_val), .prev(prev_q),
      .ie_we(ie_sel), .clr_we(ip_sel), .wdata(bus_wdata),
      .ie(bank_ie[k]), .ip(bank_ip[k]), .hit(bank_hit[k])
    );
  end

  assign irq = |bank_hit;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_IN_VAL))  bus_rdata = in_val;
    if (bus_addr == AW'(OFS_IN_EN))   bus_rdata = in_en_q;
    if (bus_addr == AW'(OFS_OUT_EN))  bus_rdata = out_en_q;
    if (bus_addr == AW'(OFS_OUT_VAL)) bus_rdata = out_val_q;
    if (bus_addr == AW'(OFS_OUT_XOR)) bus_rdata = out_xor_q;
    for (int k = 0; k < NB; k++) begin
      if (bus_addr == AW'(OFS_IE_BASE + BANK_STRIDE * k)) bus_rdata = bank_ie[k];
      if (bus_addr == AW'(OFS_IP_BASE + BANK_STRIDE * k)) bus_rdata = bank_ip[k];
    end
  end
endmodule

// File: rtl/pin_port_chk.sv
module pin_port_chk
  import pin_port_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic          irq,
  input logic [W-1:0]  in_val,
  input logic [W-1:0]  rise_ip,
  input logic [W-1:0]  high_ip,
  input logic          ie_any
);
  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(OFS_OUT_EN)) |=> $stable(pad_oe));

  // R2
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == AW'(OFS_OUT_VAL) || bus_addr == AW'(OFS_OUT_XOR)))
    |=> $stable(pad_out));

  // R4
  rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_ip & ~$past(rise_ip) & ~$past(in_val)) == '0));

  // R5
  high_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~high_ip & $past(in_val)) == '0));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_any |-> !irq);
endmodule

bind pin_port_irq pin_port_chk #(.W(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .in_val(in_val),
  .rise_ip(bank_ip[0]), .high_ip(bank_ip[2]), .ie_any(|bank_ie)
);

// File: tb/sim_pin_port_irq.sv
module sim_pin_port_irq;
  localparam int PERIOD = 10;
  localparam logic [7:0] A_IN = 8'h00, A_IEN = 8'h04, A_OEN = 8'h08, A_OVAL = 8'h0C,
    A_RIE = 8'h18, A_RIP = 8'h1C, A_FIE = 8'h20, A_FIP = 8'h24,
    A_HIE = 8'h28, A_HIP = 8'h2C, A_LIE = 8'h30, A_LIP = 8'h34, A_XOR = 8'h40;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, pad_in = 0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pin_port_irq u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 0; idle(3);
    for (int a = 0; a <= 'h40; a += 4) begin
      rd(8'(a), v); check("R1 reg in reset", v, 0);
    end
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irq", {31'd0, irq}, 0);
    @(negedge clk); rst_n = 1; idle(5);
    rd(A_LIP, v); check("R5 low pending after reset", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    logic [7:0] regs [9] = '{A_IEN, A_OEN, A_OVAL, A_XOR, A_RIE, A_FIE, A_HIE, A_LIE, A_IEN};
    for (int i = 0; i < 8; i++) begin
      wr(regs[i], 32'h1357_0000 + 32'(i * 'h111));
      rd(regs[i], v); check("R9 readback", v, 32'h1357_0000 + 32'(i * 'h111));
      wr(regs[i], 0);
    end
    rd(8'h10, v); check("R8 unmapped read", v, 0);
    wr(A_LIP, 32'hFFFF_FFFF);
  endtask

  task automatic t_loopback();
    logic [31:0] v;
    pad_in = 0;
    wr(A_IEN, 32'hFFFF_FFFF); wr(A_OEN, 32'hFFFF_FFFF); idle(4);
    wr(A_OVAL, 32'h0000_00A5);
    rd(A_IN, v); check("R3 old value right after write", v, 0);
    @(negedge clk); rd(A_IN, v); check("R3 old value one cycle later", v, 0);
    @(negedge clk); rd(A_IN, v); check("R3 new value two cycles later", v, 32'h0000_00A5);
    check("R2 pad_out", pad_out, 32'h0000_00A5);
    wr(A_IN, 32'hFFFF_0000); idle(3);
    rd(A_IN, v); check("R8 input write ignored", v, 32'h0000_00A5);
  endtask

  task automatic t_drive();
    logic [31:0] v;
    pad_in = 32'h00F0_0000;
    wr(A_OEN, 32'hFF00_00FF); idle(4);
    check("R2 pad_oe", pad_oe, 32'hFF00_00FF);
    rd(A_OVAL, v); check("R2 drive value kept", v, 32'h0000_00A5);
    rd(A_IN, v); check("R3 mixed pad and drive", v, 32'h00F0_00A5);
    wr(A_XOR, 32'hFFFF_FFFF); idle(4);
    check("R2 inverted pad_out", pad_out, 32'hFFFF_FF5A);
    rd(A_IN, v); check("R3 inverted loopback", v, 32'hFFF0_005A);
    wr(A_XOR, 0); pad_in = 0; wr(A_OEN, 32'hFFFF_FFFF); wr(A_OVAL, 0); idle(5);
    for (int k = 0; k < 4; k++) wr(8'(8'h1C + 8 * k), 32'hFFFF_FFFF);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(A_OVAL, 32'h0000_FF00); idle(5);
    rd(A_RIP, v); check("R4 rise pending without enable", v, 32'h0000_FF00);
    rd(A_FIP, v); check("R4 no fall on rise", v, 0);
    check("R7 irq off with no enables", {31'd0, irq}, 0);
    wr(A_OVAL, 32'h0000_0F00); idle(5);
    rd(A_FIP, v); check("R4 fall pending", v, 32'h0000_F000);
    wr(A_RIP, 32'hFFFF_FFFF); wr(A_FIP, 32'hFFFF_FFFF);
    wr(A_IEN, 32'hFFFF_F0FF); idle(5);
    rd(A_FIP, v); check("R4 fall from input disable", v, 32'h0000_0F00);
    wr(A_IEN, 32'hFFFF_FFFF); idle(5);
    rd(A_RIP, v); check("R4 rise from input enable", v, 32'h0000_0F00);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(A_RIP, 32'h0000_0300);
    rd(A_RIP, v); check("R6 partial clear", v, 32'h0000_0C00);
    wr(A_HIP, 32'hFFFF_FFFF);
    rd(A_HIP, v); check("R6 high level persists", v, 32'h0000_0F00);
    wr(A_LIP, 32'hFFFF_FFFF);
    rd(A_LIP, v); check("R6 low level persists", v, 32'hFFFF_F0FF);
  endtask

  task automatic t_irq();
    wr(A_HIE, 32'h0000_0100);
    check("R7 irq on high-enable of high pin", {31'd0, irq}, 1);
    wr(A_HIP, 32'h0000_0100);
    check("R6 level irq stays after clear", {31'd0, irq}, 1);
    wr(A_HIE, 32'h0001_0000);
    check("R7 irq off for low pin high-enable", {31'd0, irq}, 0);
    wr(A_HIE, 0); wr(A_LIE, 32'h0001_0000);
    check("R7 irq on low-enable", {31'd0, irq}, 1);
    wr(A_LIE, 0); wr(A_RIE, 32'h0000_0400);
    check("R7 irq on rise-enable", {31'd0, irq}, 1);
    wr(A_RIP, 32'h0000_0400);
    check("R7 irq off after rise clear", {31'd0, irq}, 0);
    wr(A_RIE, 0); wr(A_FIE, 32'h0000_0800);
    check("R7 irq on fall-enable", {31'd0, irq}, 1);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_loopback();
    t_drive();
    t_edges();
    t_clear();
    t_irq();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule